// File: doc/BRIEF.md
# Split-Bus Word ROM Matrix

This block is a read-only store of 16-bit words arranged as a matrix of rows. Each row is split into a low byte and a high byte. Each half has its own row select line. The selected halves are OR-ed onto two half-buses that run past every row. A stored 1 is a present cell. A stored 0 is an absent cell. A row whose select is off puts nothing on a bus, so a bus carries exactly the selected cells.

An address and a width mode are decoded into the per-row, per-half selects. An output muxer then presents the same array in one of three shapes:
- as bytes, where one half of one row is selected;
- as 16-bit words, where both halves of one row are selected;
- as 32-bit words built from two consecutive rows.

Two consecutive rows must be read in the same access. For that reason the matrix is read through two lanes of buses: one lane for the addressed row and one for the row after it.

The contents come from a constant parameter. The read path is purely combinational. It has no clock, no reset and no handshake: the address and mode are plain control pins and the data pin follows them within the same cycle.

Top module: `split_rom`

## Requirements
- R1: With `rd_mode` = 2'b01 (16-bit) and `rd_addr` < WORDS, `rd_data` equals {16'h0000, word[rd_addr]}. The low byte of a word is bits 7:0 and the high byte is bits 15:8.
- R2: With `rd_mode` = 2'b00 (8-bit) and `rd_addr` < 2*WORDS, `rd_data[7:0]` is a byte of word[rd_addr >> 1]. It is the low byte when `rd_addr[0]` is 0 and the high byte when it is 1. `rd_data[31:8]` is zero.
- R3: With `rd_mode` = 2'b10 (32-bit) and `rd_addr` + 1 < WORDS, `rd_data` equals {word[rd_addr+1], word[rd_addr]}. The start address need not be even.
- R4: An address beyond the range of its mode reads as all zeros. The limits are:
  - 8-bit: `rd_addr` >= 2*WORDS;
  - 16-bit: `rd_addr` >= WORDS;
  - 32-bit: `rd_addr` >= WORDS-1.
- R5: `rd_mode` = 2'b11 is reserved. It selects no row and reads as all zeros for every address.
- R6: `rd_data` is a combinational function of `rd_addr` and `rd_mode` only. A change on either pin is reflected without any clock edge.
- R7: The stored bits are reproduced exactly. An all-zero word reads as zero and an all-ones word reads as ones. A neighbouring row never leaks onto the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd_mode | input | 2 | Width mode: 00 byte, 01 16-bit word, 10 32-bit pair, 11 reserved |
| rd_addr | input | ADDR_W ($clog2(WORDS)+2) | Element address in units of the selected width |
| rd_data | output | 4*HALF_W | Read data, zero-extended in the narrow modes |

## Verification
The two functions that fall in the same access are the reads of two adjacent rows in 32-bit mode. Both rows are selected at once, and their cells must land on separate lanes instead of being OR-ed together on one bus. The bench provokes this with every start address, including odd starts and the last pair, where the second row would fall off the end. The test image holds words with disjoint bit patterns, an all-zero word and an all-ones word, so any cross-lane OR or any leak from a neighbour changes the observed value. Each read is judged against a concatenation that the bench computes from its own copy of the image.

// File: rtl/split_rom_pkg.sv
package split_rom_pkg;

  typedef enum logic [1:0] {
    MODE_BYTE = 2'b00,
    MODE_WORD = 2'b01,
    MODE_PAIR = 2'b10,
    MODE_RSVD = 2'b11
  } rd_mode_e;

endpackage

// File: rtl/split_rom_decode.sv
module split_rom_decode
  import split_rom_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  rd_mode_e          mode,
  output logic [WORDS-1:0]  sel_lo_a,
  output logic [WORDS-1:0]  sel_hi_a,
  output logic [WORDS-1:0]  sel_lo_b,
  output logic [WORDS-1:0]  sel_hi_b
);

  int   row_a;
  logic in_range;
  logic want_lo;
  logic want_hi;

  always_comb begin
    row_a    = int'(addr);
    in_range = 1'b0;
    want_lo  = 1'b1;
    want_hi  = 1'b1;
    case (mode)
      MODE_BYTE: begin
        row_a    = int'(addr) >> 1;
        in_range = int'(addr) < 2 * WORDS;
        want_lo  = ~addr[0];
        want_hi  = addr[0];
      end
      MODE_WORD: in_range = int'(addr) < WORDS;
      MODE_PAIR: in_range = int'(addr) < WORDS - 1;
      default:   in_range = 1'b0;
    endcase
  end

  always_comb begin
    for (int r = 0; r < WORDS; r++) begin
      sel_lo_a[r] = in_range && (row_a == r) && want_lo;
      sel_hi_a[r] = in_range && (row_a == r) && want_hi;
      sel_lo_b[r] = in_range && (mode == MODE_PAIR) && (row_a + 1 == r);
      sel_hi_b[r] = in_range && (mode == MODE_PAIR) && (row_a + 1 == r);
    end
  end

  always_comb begin
    p_one_row_per_bus_r7: assert ($onehot0(sel_lo_a) && $onehot0(sel_hi_a) &&
                                  $onehot0(sel_lo_b) && $onehot0(sel_hi_b))
      else $error("more than one row drives a half-bus");
    p_reserved_idle_r5: assert (mode != MODE_RSVD ||
                                (sel_lo_a == '0 && sel_hi_a == '0 &&
                                 sel_lo_b == '0 && sel_hi_b == '0))
      else $error("reserved mode selected a row");
    p_byte_one_half_r2: assert (mode != MODE_BYTE ||
                                ($countones({sel_lo_a, sel_hi_a}) <= 1 &&
                                 sel_lo_b == '0 && sel_hi_b == '0))
      else $error("byte mode selected more than one half");
  end

endmodule

// File: rtl/split_rom_lane.sv
module split_rom_lane #(
  parameter int                          WORDS    = 8,
  parameter int                          HALF_W   = 8,
  parameter logic [WORDS*2*HALF_W-1:0]   CONTENTS = '0
) (
  input  logic [WORDS-1:0]  sel_lo,
  input  logic [WORDS-1:0]  sel_hi,
  output logic [HALF_W-1:0] bus_lo,
  output logic [HALF_W-1:0] bus_hi
);

  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] row_lo [WORDS];
  logic [HALF_W-1:0] row_hi [WORDS];

  for (genvar r = 0; r < WORDS; r++) begin : g_row
    localparam logic [HALF_W-1:0] CELLS_LO = CONTENTS[r*WORD_W +: HALF_W];
    localparam logic [HALF_W-1:0] CELLS_HI = CONTENTS[r*WORD_W+HALF_W +: HALF_W];
    assign row_lo[r] = CELLS_LO & {HALF_W{sel_lo[r]}};
    assign row_hi[r] = CELLS_HI & {HALF_W{sel_hi[r]}};
  end

  always_comb begin
    bus_lo = '0;
    bus_hi = '0;
    for (int r = 0; r < WORDS; r++) begin
      bus_lo |= row_lo[r];
      bus_hi |= row_hi[r];
    end
  end

  always_comb begin
    p_idle_bus_zero_r4: assert ((sel_lo != '0 || bus_lo == '0) &&
                                (sel_hi != '0 || bus_hi == '0))
      else $error("half-bus carries data with no row selected");
  end

endmodule

// File: rtl/split_rom_outmux.sv
module split_rom_outmux
  import split_rom_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  rd_mode_e            mode,
  input  logic [HALF_W-1:0]   a_lo,
  input  logic [HALF_W-1:0]   a_hi,
  input  logic [HALF_W-1:0]   b_lo,
  input  logic [HALF_W-1:0]   b_hi,
  output logic [4*HALF_W-1:0] data
);

  always_comb begin
    case (mode)
      MODE_BYTE: data = {{(3*HALF_W){1'b0}}, a_lo | a_hi};
      MODE_WORD: data = {{(2*HALF_W){1'b0}}, a_hi, a_lo};
      MODE_PAIR: data = {b_hi, b_lo, a_hi, a_lo};
      default:   data = '0;
    endcase
  end

  always_comb begin
    p_byte_halves_exclusive_r2: assert (mode != MODE_BYTE || a_lo == '0 || a_hi == '0)
      else $error("both halves active in byte mode");
    p_byte_upper_zero_r2: assert (mode != MODE_BYTE || data[4*HALF_W-1:HALF_W] == '0)
      else $error("byte mode upper bits not zero");
  end

endmodule

// File: rtl/split_rom.sv
module split_rom
  import split_rom_pkg::*;
#(
  parameter int                        WORDS    = 8,
  parameter int                        HALF_W   = 8,
  parameter logic [WORDS*2*HALF_W-1:0] CONTENTS = 128'hF00F_0FF0_3C3C_C3C3_AA55_55AA_1234_8001,
  localparam int                       ADDR_W   = $clog2(WORDS) + 2
) (
  input  logic [1:0]          rd_mode,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [4*HALF_W-1:0] rd_data
);

  rd_mode_e          mode;
  logic [WORDS-1:0]  sel_lo_a, sel_hi_a, sel_lo_b, sel_hi_b;
  logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;

  assign mode = rd_mode_e'(rd_mode);

  split_rom_decode #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_decode (
    .addr     (rd_addr),
    .mode     (mode),
    .sel_lo_a (sel_lo_a),
    .sel_hi_a (sel_hi_a),
    .sel_lo_b (sel_lo_b),
    .sel_hi_b (sel_hi_b)
  );

  split_rom_lane #(.WORDS(WORDS), .HALF_W(HALF_W), .CONTENTS(CONTENTS)) u_lane_a (
    .sel_lo (sel_lo_a),
    .sel_hi (sel_hi_a),
    .bus_lo (a_lo),
    .bus_hi (a_hi)
  );

  split_rom_lane #(.WORDS(WORDS), .HALF_W(HALF_W), .CONTENTS(CONTENTS)) u_lane_b (
    .sel_lo (sel_lo_b),
    .sel_hi (sel_hi_b),
    .bus_lo (b_lo),
    .bus_hi (b_hi)
  );

  split_rom_outmux #(.HALF_W(HALF_W)) u_outmux (
    .mode (mode),
    .a_lo (a_lo),
    .a_hi (a_hi),
    .b_lo (b_lo),
    .b_hi (b_hi),
    .data (rd_data)
  );

  always_comb begin
    p_second_lane_idle_r3: assert (mode == MODE_PAIR || (b_lo == '0 && b_hi == '0))
      else $error("second lane active outside 32-bit mode");
    p_reserved_reads_zero_r5: assert (mode != MODE_RSVD || rd_data == '0)
      else $error("reserved mode returned data");
  end

endmodule

// File: tb/split_rom_bench.sv
module split_rom_bench;

  localparam int WORDS  = 8;
  localparam int HALF_W = 8;
  localparam int ADDR_W = $clog2(WORDS) + 2;

  function automatic logic [15:0] word_of(int i);
    if (i == 2) return 16'h0000;
    if (i == 5) return 16'hFFFF;
    return 16'((i + 1) * 11065) ^ 16'h5A0F;
  endfunction

  function automatic logic [WORDS*16-1:0] make_image();
    logic [WORDS*16-1:0] img;
    img = '0;
    for (int i = 0; i < WORDS; i++) img[i*16 +: 16] = word_of(i);
    return img;
  endfunction

  localparam logic [WORDS*16-1:0] IMAGE = make_image();

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        rd_mode = 2'b00;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0]       rd_data;
  int                n_checks = 0;
  int                n_fail = 0;
  bit                done = 1'b0;

  always #5 clk = ~clk;

  split_rom #(.WORDS(WORDS), .HALF_W(HALF_W), .CONTENTS(IMAGE)) u_split_rom (
    .rd_mode (rd_mode),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  function automatic logic [31:0] expect_of(int m, int a);
    logic [15:0] w;
    case (m)
      0: begin
        if (a >= 2 * WORDS) return 32'h0;
        w = word_of(a / 2);
        return (a % 2 == 1) ? {24'h0, w[15:8]} : {24'h0, w[7:0]};
      end
      1: return (a < WORDS) ? {16'h0, word_of(a)} : 32'h0;
      2: return (a < WORDS - 1) ? {word_of(a + 1), word_of(a)} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int m, int a);
    case (m)
      0: return (a < 2 * WORDS) ? "R2" : "R4";
      1: return (a < WORDS) ? "R1" : "R4";
      2: return (a < WORDS - 1) ? "R3" : "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] exp);
    n_checks++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s mode=%0d addr=%0d actual=%h expected=%h",
               req, rd_mode, rd_addr, rd_data, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // Idle inputs (byte mode, address 0): low byte of word 0, R2
    check("R2", expect_of(0, 0));

    // Exhaustive sweep of every mode and every address; R1 R2 R3 R4 R5
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < (1 << ADDR_W); a++) begin
        @(posedge clk);
        #1;
        rd_mode = 2'(m);
        rd_addr = ADDR_W'(a);
        #2;
        check(tag_of(m, a), expect_of(m, a));
      end
    end

    // R6: several changes within one half clock period, no edge in between
    @(posedge clk);
    #1 rd_mode = 2'b10; rd_addr = ADDR_W'(6);
    #0.5 check("R6", expect_of(2, 6));
    rd_addr = ADDR_W'(7);
    #0.5 check("R6", 32'h0);
    rd_mode = 2'b00; rd_addr = ADDR_W'(11);
    #0.5 check("R6", expect_of(0, 11));

    // R7: zero word and all-ones word, read singly and across the pair seam
    @(posedge clk);
    #1 rd_mode = 2'b01; rd_addr = ADDR_W'(2);
    #1 check("R7", 32'h0000_0000);
    rd_addr = ADDR_W'(5);
    #1 check("R7", 32'h0000_FFFF);
    rd_mode = 2'b10; rd_addr = ADDR_W'(4);
    #1 check("R7", {16'hFFFF, word_of(4)});
    rd_addr = ADDR_W'(1);
    #1 check("R7", {16'h0000, word_of(1)});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule